// File: doc/BRIEF.md
# Peripheral Standby and Clock-Gating Controller

This block controls power-down for a small set of on-chip peripherals. A bus-visible stop register holds one bit per peripheral. Setting a bit removes that peripheral's clock enable, and clearing the bit gives the enable back. Before the clock is removed, a peripheral whose policy asks for it receives a one-cycle register-initialize strobe.

The block also tracks a chip-wide software standby state. A standby request first strobes the peripherals that clear their registers on standby. It then drops every peripheral clock, the core clock enable and the external clock pin. Only a power-on reset brings the chip out of standby. A manual reset or an interrupt during standby does not wake the chip; each one sets a sticky error flag instead. On the way out, the controller waits for the oscillator-settled input before it releases the internal clocks, and it keeps the clock pin running from the moment the reset arrives.

Bus accesses are handled in three ways. Address 0 selects the stop register. Addresses 1..N_MOD select peripheral k = address−1, and such an access is forwarded only when that peripheral is running. Accesses to a stopped peripheral are reported as errors.

Top module: `pstby_ctrl`

## Requirements
- R1: A write to address 0 updates the stop register at clock edge t. Each `clk_en` bit then equals the inverse of its stop bit from edge t+1, while the controller is in run state.
- R2: A read of address 0 returns the stop register contents on `bus_rdata` one clock later, so a cleared bit reads back as 0. In every cycle without such a read, `bus_rdata` is 0.
- R3: `por_rst` clears exactly the stop bits set in POR_CLR_MASK (default 8'h07) and leaves every other stop bit unchanged.
- R4: A `stby_req` in run state has three effects. First, it raises `init_stb` for the SW_INIT_MASK bits (default 8'hE8) for one cycle. One cycle later, `clk_en` and `core_clk_en` go to 0. One cycle after that, `ck_pin_en` goes to 0.
- R5: In standby, `mres` sets the sticky flag `err_mres` and does not wake the chip.
- R6: In standby, `irq` sets the sticky flag `err_irq` and does not wake the chip.
- R7: `por_rst` during standby starts a wake phase. In that phase `core_clk_en` stays 0 until `osc_ok` is seen high, and it becomes 1 two cycles after that edge.
- R8: `ck_pin_en` is 1 in the cycle after any `por_rst` edge and stays 1 for the whole wake phase.
- R9: A stop bit going 0→1 raises `init_stb` for that bit only if the bit is set in MS_INIT_MASK (default 8'hF0). Bit 3 (standby-init only) therefore gets no strobe, and bit 4 (module-stop-init only) does.
- R10: Each initialize strobe lasts one cycle. For a bit whose clock was running, the strobe appears while `clk_en` is still 1, and `clk_en` falls in the following cycle.
- R11: An access to address k+1 (for k < N_MOD) has two outcomes. If stop bit k is 1, it pulses `acc_err` for one cycle with `per_sel` at 0. If stop bit k is 0, it drives `per_sel` one-hot at bit k for one cycle.
- R12: While `cold_rst` is high, the outputs are held as follows: stop register = STOP_INIT (0), state = run, all `clk_en`/`init_stb`/`per_sel` = 0, `core_clk_en` = 0, `ck_pin_en` = 1, and both error flags = 0.
- R13: Bus writes, reads and accesses made outside run state, or while `por_rst` is high, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous supply-up reset, initializes everything |
| por_rst | input | 1 | Synchronous power-on reset, partial stop clear, standby exit |
| mres | input | 1 | Manual reset request |
| irq | input | 1 | Interrupt request |
| stby_req | input | 1 | Software standby request |
| osc_ok | input | 1 | Oscillator settled |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | 0 = stop register, k+1 = peripheral k |
| bus_wdata | input | N_MOD | Write data for stop register |
| bus_rdata | output | N_MOD | Stop register read data |
| per_sel | output | N_MOD | Forwarded one-hot peripheral access |
| acc_err | output | 1 | Access to a stopped peripheral |
| clk_en | output | N_MOD | Per-peripheral clock enable |
| init_stb | output | N_MOD | Per-peripheral register-initialize strobe |
| core_clk_en | output | 1 | Internal clock release |
| ck_pin_en | output | 1 | External clock pin running |
| err_mres | output | 1 | Sticky: manual reset seen in standby |
| err_irq | output | 1 | Sticky: interrupt seen in standby |

## Verification
Stop-register writes of all-ones and then all-zeros separate the two retention policies: the standby-only bit 3 gets no strobe, while bit 4 does. A power-on reset with all stop bits set tells the cleared subset apart from the kept bits. A directed standby pass injects a manual reset, an interrupt and a bus write, then holds `osc_ok` low through the reset. This shows that none of these wake the chip and that the clocks wait for the oscillator. Finally, a long stretch of mixed random traffic, including invalid addresses and resets that land inside standby, is compared cycle by cycle against a behavioural model.

// File: rtl/pstby_pkg.sv
package pstby_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_STBY  = 2'd2,
    ST_WAKE  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pstby_fsm.sv
module pstby_fsm
  import pstby_pkg::*;
(
  input  logic       clk,
  input  logic       cold_rst,
  input  logic       por_rst,
  input  logic       mres,
  input  logic       irq,
  input  logic       stby_req,
  input  logic       osc_ok,
  output pwr_state_e state_o,
  output logic       core_clk_en_o,
  output logic       ck_pin_en_o,
  output logic       err_mres_o,
  output logic       err_irq_o
);
  pwr_state_e state_q, state_d;
  logic core_q, pin_q, emr_q, eirq_q;

  always_comb begin
    state_d = state_q;
    if (por_rst) begin
      if (state_q == ST_RUN) state_d = ST_RUN;
      else if (state_q == ST_WAKE && osc_ok) state_d = ST_RUN;
      else state_d = ST_WAKE;
    end else begin
      case (state_q)
        ST_RUN:   if (stby_req) state_d = ST_ENTER;
        ST_ENTER: state_d = ST_STBY;
        ST_STBY:  state_d = ST_STBY;
        ST_WAKE:  if (osc_ok) state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      state_q <= ST_RUN;
      core_q  <= 1'b0;
      pin_q   <= 1'b1;
      emr_q   <= 1'b0;
      eirq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      core_q  <= (state_q == ST_RUN) && !por_rst;
      pin_q   <= (state_q != ST_STBY) || por_rst;
      if (!por_rst && state_q == ST_STBY) begin
        emr_q  <= emr_q | mres;
        eirq_q <= eirq_q | irq;
      end
    end
  end

  assign state_o       = state_q;
  assign core_clk_en_o = core_q;
  assign ck_pin_en_o   = pin_q;
  assign err_mres_o    = emr_q;
  assign err_irq_o     = eirq_q;
endmodule

// File: rtl/pstby_stopreg.sv
module pstby_stopreg #(
  parameter int          N_MOD        = 8,
  parameter logic [N_MOD-1:0] STOP_INIT    = '0,
  parameter logic [N_MOD-1:0] POR_CLR_MASK = 8'h07,
  parameter logic [N_MOD-1:0] MS_INIT_MASK = 8'hF0
) (
  input  logic             clk,
  input  logic             cold_rst,
  input  logic             por_rst,
  input  logic             bus_ok,
  input  logic             we0,
  input  logic             re0,
  input  logic [N_MOD-1:0] wdata,
  output logic [N_MOD-1:0] stop_o,
  output logic [N_MOD-1:0] rdata_o,
  output logic [N_MOD-1:0] ms_rise_o
);
  logic [N_MOD-1:0] stop_q, rdata_q;

  assign ms_rise_o = (bus_ok && we0) ? (wdata & ~stop_q & MS_INIT_MASK) : '0;

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      stop_q  <= STOP_INIT;
      rdata_q <= '0;
    end else if (por_rst) begin
      stop_q  <= stop_q & ~POR_CLR_MASK;
      rdata_q <= '0;
    end else begin
      rdata_q <= (bus_ok && re0) ? stop_q : '0;
      if (bus_ok && we0) stop_q <= wdata;
    end
  end

  assign stop_o  = stop_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/pstby_acc.sv
module pstby_acc #(
  parameter int N_MOD  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              por_rst,
  input  logic              bus_ok,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_MOD-1:0]  stop,
  output logic [N_MOD-1:0]  per_sel_o,
  output logic              acc_err_o
);
  logic [N_MOD-1:0] hit;
  logic [N_MOD-1:0] sel_q;
  logic             err_q;
  logic             acc;

  for (genvar i = 0; i < N_MOD; i++) begin : g_dec
    assign hit[i] = (bus_addr == ADDR_W'(i + 1));
  end

  assign acc = bus_ok && (bus_we || bus_re);

  always_ff @(posedge clk) begin
    if (cold_rst || por_rst) begin
      sel_q <= '0;
      err_q <= 1'b0;
    end else begin
      sel_q <= acc ? (hit & ~stop) : '0;
      err_q <= acc && (|(hit & stop));
    end
  end

  assign per_sel_o = sel_q;
  assign acc_err_o = err_q;
endmodule

// File: rtl/pstby_ctrl.sv
module pstby_ctrl
  import pstby_pkg::*;
#(
  parameter int               N_MOD        = 8,
  parameter logic [N_MOD-1:0] STOP_INIT    = '0,
  parameter logic [N_MOD-1:0] POR_CLR_MASK = 8'h07,
  parameter logic [N_MOD-1:0] SW_INIT_MASK = 8'hE8,
  parameter logic [N_MOD-1:0] MS_INIT_MASK = 8'hF0,
  localparam int              ADDR_W       = $clog2(N_MOD + 1)
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              por_rst,
  input  logic              mres,
  input  logic              irq,
  input  logic              stby_req,
  input  logic              osc_ok,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_MOD-1:0]  bus_wdata,
  output logic [N_MOD-1:0]  bus_rdata,
  output logic [N_MOD-1:0]  per_sel,
  output logic              acc_err,
  output logic [N_MOD-1:0]  clk_en,
  output logic [N_MOD-1:0]  init_stb,
  output logic              core_clk_en,
  output logic              ck_pin_en,
  output logic              err_mres,
  output logic              err_irq
);
  pwr_state_e       state;
  logic             bus_ok, is_reg;
  logic [N_MOD-1:0] stop, ms_rise;
  logic [N_MOD-1:0] clk_en_q, init_q;

  assign bus_ok = (state == ST_RUN) && !por_rst;
  assign is_reg = (bus_addr == '0);

  pstby_fsm u_fsm (
    .clk(clk), .cold_rst(cold_rst), .por_rst(por_rst), .mres(mres), .irq(irq),
    .stby_req(stby_req), .osc_ok(osc_ok), .state_o(state),
    .core_clk_en_o(core_clk_en), .ck_pin_en_o(ck_pin_en),
    .err_mres_o(err_mres), .err_irq_o(err_irq)
  );

  pstby_stopreg #(
    .N_MOD(N_MOD), .STOP_INIT(STOP_INIT),
    .POR_CLR_MASK(POR_CLR_MASK), .MS_INIT_MASK(MS_INIT_MASK)
  ) u_stop (
    .clk(clk), .cold_rst(cold_rst), .por_rst(por_rst), .bus_ok(bus_ok),
    .we0(bus_we && is_reg), .re0(bus_re && is_reg), .wdata(bus_wdata),
    .stop_o(stop), .rdata_o(bus_rdata), .ms_rise_o(ms_rise)
  );

  pstby_acc #(.N_MOD(N_MOD), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .cold_rst(cold_rst), .por_rst(por_rst), .bus_ok(bus_ok),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .stop(stop),
    .per_sel_o(per_sel), .acc_err_o(acc_err)
  );

  always_ff @(posedge clk) begin
    if (cold_rst || por_rst) begin
      clk_en_q <= '0;
      init_q   <= '0;
    end else begin
      clk_en_q <= (state == ST_RUN) ? ~stop : '0;
      init_q   <= ms_rise | ((state == ST_RUN && stby_req) ? SW_INIT_MASK : '0);
    end
  end

  assign clk_en   = clk_en_q;
  assign init_stb = init_q;
endmodule

// File: rtl/pstby_ctrl_chk.sv
module pstby_ctrl_chk #(
  parameter int N_MOD = 8
) (
  input logic             clk,
  input logic             cold_rst,
  input logic             por_rst,
  input logic [N_MOD-1:0] per_sel,
  input logic             acc_err,
  input logic [N_MOD-1:0] clk_en,
  input logic             core_clk_en,
  input logic             ck_pin_en,
  input logic             err_mres,
  input logic             err_irq
);
  AST_STBY_GATED: assert property (@(posedge clk) disable iff (cold_rst)
    !ck_pin_en |-> (clk_en == '0 && !core_clk_en)); // R4
  AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (cold_rst)
    acc_err |-> (per_sel == '0)); // R11
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (cold_rst)
    $onehot0(per_sel)); // R11
  AST_MRES_STICKY: assert property (@(posedge clk) disable iff (cold_rst)
    err_mres |=> err_mres); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (cold_rst)
    err_irq |=> err_irq); // R6
  AST_POR_PIN_ON: assert property (@(posedge clk) disable iff (cold_rst)
    por_rst |=> (ck_pin_en && !core_clk_en)); // R8
endmodule

bind pstby_ctrl pstby_ctrl_chk #(.N_MOD(N_MOD)) u_chk (
  .clk(clk), .cold_rst(cold_rst), .por_rst(por_rst), .per_sel(per_sel),
  .acc_err(acc_err), .clk_en(clk_en), .core_clk_en(core_clk_en),
  .ck_pin_en(ck_pin_en), .err_mres(err_mres), .err_irq(err_irq)
);

// File: tb/pstby_ctrl_tb.sv
module pstby_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int AW = 4;
  localparam logic [N-1:0] POR_M = 8'h07;
  localparam logic [N-1:0] SW_M  = 8'hE8;
  localparam logic [N-1:0] MS_M  = 8'hF0;

  logic clk = 1'b0;
  logic cold_rst = 1'b1, por_rst = 1'b1, mres = 0, irq = 0, stby_req = 0, osc_ok = 1;
  logic bus_we = 0, bus_re = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata, per_sel, clk_en, init_stb;
  logic acc_err, core_clk_en, ck_pin_en, err_mres, err_irq;

  int nvec = 0, nbad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pstby_ctrl u_dut (
    .clk(clk), .cold_rst(cold_rst), .por_rst(por_rst), .mres(mres), .irq(irq),
    .stby_req(stby_req), .osc_ok(osc_ok), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .per_sel(per_sel), .acc_err(acc_err), .clk_en(clk_en), .init_stb(init_stb),
    .core_clk_en(core_clk_en), .ck_pin_en(ck_pin_en), .err_mres(err_mres),
    .err_irq(err_irq)
  );

  // behavioural reference: st 0 run, 1 entering, 2 standby, 3 waking
  int st = 0;
  logic [N-1:0] m_stop, m_rd, m_sel, m_clk, m_init, m_tmp;
  logic m_aerr, m_core, m_pin, m_emr, m_eirq;

  always @(posedge clk) begin
    if (cold_rst) begin
      st <= 0; m_stop <= '0; m_rd <= '0; m_sel <= '0; m_clk <= '0; m_init <= '0;
      m_aerr <= 0; m_core <= 0; m_pin <= 1; m_emr <= 0; m_eirq <= 0;
    end else if (por_rst) begin
      m_stop <= m_stop & ~POR_M;
      if (st == 0 || (st == 3 && osc_ok)) st <= 0; else st <= 3;
      m_rd <= '0; m_sel <= '0; m_clk <= '0; m_init <= '0;
      m_aerr <= 0; m_core <= 0; m_pin <= 1;
    end else begin
      m_core <= (st == 0);
      m_pin  <= (st != 2);
      m_clk  <= (st == 0) ? ~m_stop : '0;
      m_rd <= '0; m_sel <= '0; m_aerr <= 0;
      m_tmp = '0;
      if (st == 0) begin
        if (bus_re && bus_addr == 0) m_rd <= m_stop;
        if (bus_we && bus_addr == 0) begin
          m_tmp = bus_wdata & ~m_stop & MS_M;
          m_stop <= bus_wdata;
        end
        if ((bus_we || bus_re) && bus_addr >= 1 && bus_addr <= N) begin
          if (m_stop[bus_addr-1]) m_aerr <= 1;
          else m_sel <= N'(1) << (bus_addr - 1);
        end
        if (stby_req) begin m_tmp = m_tmp | SW_M; st <= 1; end
      end else if (st == 1) st <= 2;
      else if (st == 2) begin
        if (mres) m_emr <= 1;
        if (irq) m_eirq <= 1;
      end else if (osc_ok) st <= 0;
      m_init <= m_tmp;
    end
  end

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R1 clk_en", clk_en, m_clk);
    chk("R2 bus_rdata", bus_rdata, m_rd);
    chk("R9 init_stb", init_stb, m_init);
    chk("R11 per_sel", per_sel, m_sel);
    chk("R11 acc_err", N'(acc_err), N'(m_aerr));
    chk("R7 core_clk_en", N'(core_clk_en), N'(m_core));
    chk("R8 ck_pin_en", N'(ck_pin_en), N'(m_pin));
    chk("R5 err_mres", N'(err_mres), N'(m_emr));
    chk("R6 err_irq", N'(err_irq), N'(m_eirq));
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic idle();
    bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic wr(logic [N-1:0] v);
    bus_we = 1; bus_addr = '0; bus_wdata = v; cyc(1); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nbad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    cyc(3);
    // R12 reset state
    chk("R12 clk_en", clk_en, '0);
    chk("R12 init_stb", init_stb, '0);
    chk("R12 pin/core/err", {4'b0, ck_pin_en, core_clk_en, err_mres, err_irq}, 8'h08);
    cold_rst = 0; cyc(1); por_rst = 0; cyc(2);
    chk("R1 running after reset", clk_en, 8'hFF);
    // R9/R10 stop all
    bus_we = 1; bus_addr = '0; bus_wdata = 8'hFF; cyc(1); idle();
    chk("R9 strobe only module-stop-init bits", init_stb, MS_M);
    chk("R10 clk still on during strobe", clk_en, 8'hFF);
    cyc(1);
    chk("R10 strobe single cycle", init_stb, '0);
    chk("R1 clocks stopped", clk_en, '0);
    bus_re = 1; cyc(1); idle();
    chk("R2 readback all set", bus_rdata, 8'hFF);
    // R3 partial clear by power-on reset
    por_rst = 1; cyc(2); por_rst = 0;
    bus_re = 1; cyc(1); idle();
    chk("R3 por clears subset", bus_rdata, 8'hF8);
    wr(8'h00); bus_re = 1; cyc(1); idle();
    chk("R2 cleared bits read 0", bus_rdata, 8'h00);
    cyc(1);
    chk("R1 clocks restored", clk_en, 8'hFF);
    // R11 access filter
    wr(8'h10);
    bus_re = 1; bus_addr = 4'd5; cyc(1); idle();
    chk("R11 stopped access flagged", {acc_err, per_sel[6:0]}, 8'h80);
    bus_we = 1; bus_addr = 4'd1; cyc(1); idle();
    chk("R11 running access forwarded", per_sel, 8'h01);
    wr(8'h00); cyc(1);
    // R4 standby entry
    stby_req = 1; cyc(1); stby_req = 0;
    chk("R4 sw-standby strobes", init_stb, SW_M);
    chk("R4 clocks on during strobe", clk_en, 8'hFF);
    cyc(1);
    chk("R4 clocks off", {clk_en[6:0], core_clk_en}, 8'h00);
    cyc(1);
    chk("R4 pin off", N'(ck_pin_en), '0);
    // R5/R6/R13 in standby
    mres = 1; cyc(1); mres = 0;
    irq = 1; cyc(1); irq = 0;
    bus_we = 1; bus_addr = '0; bus_wdata = 8'h55; cyc(1); idle(); cyc(1);
    chk("R5 mres flagged", N'(err_mres), 8'h01);
    chk("R6 irq flagged", N'(err_irq), 8'h01);
    chk("R5 no wake", N'(core_clk_en), '0);
    // R7/R8 reset exit waits for oscillator
    osc_ok = 0; por_rst = 1; cyc(3);
    chk("R8 pin runs in reset exit", N'(ck_pin_en), 8'h01);
    chk("R7 core held", N'(core_clk_en), '0);
    por_rst = 0; cyc(3);
    chk("R7 core waits for osc", N'(core_clk_en), '0);
    chk("R8 pin still runs", N'(ck_pin_en), 8'h01);
    osc_ok = 1; cyc(2);
    chk("R7 core released", N'(core_clk_en), 8'h01);
    bus_re = 1; cyc(1); idle();
    chk("R13 standby write ignored", bus_rdata, 8'h00);
    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bus_we    = ($urandom_range(0, 3) == 0);
      bus_re    = ($urandom_range(0, 3) == 0);
      bus_addr  = AW'($urandom_range(0, 15));
      bus_wdata = N'($urandom);
      stby_req  = ($urandom_range(0, 40) == 0);
      por_rst   = ($urandom_range(0, 50) == 0);
      osc_ok    = ($urandom_range(0, 3) != 0);
      mres      = ($urandom_range(0, 20) == 0);
      irq       = ($urandom_range(0, 20) == 0);
      cyc(1);
    end
    idle(); stby_req = 0; por_rst = 0; mres = 0; irq = 0; osc_ok = 1;
    cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule